// File: doc/BRIEF.md
# Calendar Time Counter with Dual Encoding

This block keeps wall-clock time as seven byte fields: seconds, minutes, hours, day of month, month, two-digit year and century. An external update pulse advances the seconds field by one, and carries ripple upward through minutes, hours, day, month, year and century. Each field is stored natively in the encoding selected by a mode input: packed BCD or plain binary. The hours field can run as a 24-hour count or as a 12-hour count, with bit 7 of the hours byte marking PM.

A register bus writes any field with a whole byte and reads any field back as the stored byte, unconverted. A hold input freezes the counter so that software can load a consistent time. Update-pulse generation, alarms and bus index decoding live outside this block.

Field addresses: 0 seconds, 1 minutes, 2 hours, 3 day, 4 month, 5 year, 6 century. Addresses 7 read as 0x00.

Top module: `cal_time_counter`

## Requirements
- R1: After reset the fields read seconds 0x00, minutes 0x00, hours 0x00, day 0x01, month 0x01, year 0x00, century 0x00.
- R2: A write to a field address stores the byte in the next cycle and the read port then returns it unchanged (for example year 0x80 with century 0x20, then year 0x11).
- R3: With the encoding input low (packed BCD), each update pulse adds one to seconds skipping the codes 0xA-0xF in each nibble; 0x59 seconds wraps to 0x00 and carries into minutes, 0x59 minutes wraps likewise, so 09:59:59 becomes 10:00:00 in 24-hour mode.
- R4: With the encoding input high (binary), fields count in plain binary: 9:59:59 becomes 10:00:00 as 0x0A,0x00,0x00 and 59 wraps to 0.
- R5: In 24-hour mode an hour of 23 followed by a minute carry goes to hour 0 and advances the day by one.
- R6: In 12-hour mode bit 7 of the hours byte is PM; BCD codes are 12 AM 0x12, 1 AM 0x01, 11 AM 0x11, 12 PM 0x92, 1 PM 0x81, 11 PM 0x91, binary codes are 0x0C, 0x01, 0x0B, 0x8C, 0x81, 0x8B; an hour carry takes 11 AM to 12 PM, 12 PM to 1 PM, 11 PM to 12 AM with a day advance, and 12 AM to 1 AM.
- R7: While the hold input is high, update pulses leave every field unchanged; the first pulse after hold is released adds one second (0x58 to 0x59).
- R8: A day carry wraps the day to 1 and advances the month once the day reaches the month length: 30 for months 4, 6, 9, 11, 31 for the others, and for month 2 it is 29 when the year value is divisible by 4 and 28 otherwise.
- R9: Month 12 wraps to 1 and advances the year; year 99 wraps to 0 and advances the century.
- R10: A write to a field in the same cycle as an update pulse stores the written byte in that field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Update pulse, one cycle wide, advances time by one second |
| holdSet | input | 1 | Freezes the count while high |
| modeBin | input | 1 | 1 selects binary encoding, 0 packed BCD |
| mode24 | input | 1 | 1 selects 24-hour format, 0 12-hour with PM in bit 7 |
| wrEn | input | 1 | Field write strobe |
| wrAddr | input | 3 | Field address for writes |
| wrData | input | 8 | Byte written to the field |
| rdAddr | input | 3 | Field address for reads |
| rdData | output | 8 | Stored byte of the addressed field |

## Verification
The assertions assume that software loads only legal values for the current encoding and hour format, that the encoding and format inputs do not change between a load and the pulses that follow, and that a freshly loaded day and month are nonzero. The bench keeps to this by loading every field after it sets the mode inputs, by using only valid calendar codes, and by driving the encoding input steady for each scenario. The same-cycle write-and-pulse case is the only place where a write and a pulse overlap.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int NUM_FIELDS = 7;
  localparam int ADDR_W = $clog2(NUM_FIELDS + 1);
  localparam int DATA_W = 8;

  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DAY  = 3;
  localparam int F_MON  = 4;
  localparam int F_YEAR = 5;
  localparam int F_CENT = 6;

  typedef struct packed {
    logic [NUM_FIELDS-1:0] step;
    logic [NUM_FIELDS-1:0] wrap;
    logic                  pmToggle;
    logic                  binEnc;
    logic                  hour12;
  } strobe_t;

  function automatic logic [DATA_W-1:0] rstVal(input int idx);
    return (idx == F_DAY || idx == F_MON) ? DATA_W'(1) : '0;
  endfunction
endpackage

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import cal_pkg::*;
(
  input  logic                             tick,
  input  logic                             holdSet,
  input  logic                             modeBin,
  input  logic                             mode24,
  input  logic [NUM_FIELDS-1:0][DATA_W-1:0] fldBus,
  output strobe_t                          st
);
  function automatic logic [DATA_W-1:0] toBin(input logic [DATA_W-1:0] v, input logic bin);
    logic [DATA_W-1:0] hi;
    hi = {4'b0, v[7:4]};
    return bin ? v : (hi << 3) + (hi << 1) + {4'b0, v[3:0]};
  endfunction

  function automatic logic [DATA_W-1:0] monthLen(input logic [DATA_W-1:0] mon,
                                                 input logic [DATA_W-1:0] yr);
    case (mon)
      8'd2:                      monthLen = (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:   monthLen = 8'd30;
      default:                   monthLen = 8'd31;
    endcase
  endfunction

  logic [DATA_W-1:0] secV, minV, hourV, dayV, monV, yearV, centV;
  logic              advance, dayCarry, isPm;

  always_comb begin
    secV  = toBin(fldBus[F_SEC], modeBin);
    minV  = toBin(fldBus[F_MIN], modeBin);
    hourV = toBin({1'b0, fldBus[F_HOUR][6:0]}, modeBin);
    dayV  = toBin(fldBus[F_DAY], modeBin);
    monV  = toBin(fldBus[F_MON], modeBin);
    yearV = toBin(fldBus[F_YEAR], modeBin);
    centV = toBin(fldBus[F_CENT], modeBin);
    isPm  = fldBus[F_HOUR][7];
    advance = tick && !holdSet;

    st = '0;
    st.binEnc = modeBin;
    st.hour12 = !mode24;

    st.step[F_SEC] = advance;
    st.wrap[F_SEC] = advance && (secV >= 8'd59);
    st.step[F_MIN] = st.wrap[F_SEC];
    st.wrap[F_MIN] = st.step[F_MIN] && (minV >= 8'd59);
    st.step[F_HOUR] = st.wrap[F_MIN];
    if (mode24) begin
      st.wrap[F_HOUR] = st.step[F_HOUR] && (hourV >= 8'd23);
      dayCarry        = st.wrap[F_HOUR];
    end else begin
      st.wrap[F_HOUR] = st.step[F_HOUR] && (hourV >= 8'd12);
      st.pmToggle     = st.step[F_HOUR] && (hourV == 8'd11);
      dayCarry        = st.pmToggle && isPm;
    end
    st.step[F_DAY]  = dayCarry;
    st.wrap[F_DAY]  = dayCarry && (dayV >= monthLen(monV, yearV));
    st.step[F_MON]  = st.wrap[F_DAY];
    st.wrap[F_MON]  = st.step[F_MON] && (monV >= 8'd12);
    st.step[F_YEAR] = st.wrap[F_MON];
    st.wrap[F_YEAR] = st.step[F_YEAR] && (yearV >= 8'd99);
    st.step[F_CENT] = st.wrap[F_YEAR];
    st.wrap[F_CENT] = st.step[F_CENT] && (centV >= 8'd99);
  end
endmodule

// File: rtl/cal_datapath.sv
module cal_datapath
  import cal_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  strobe_t                           st,
  input  logic                              wrEn,
  input  logic [ADDR_W-1:0]                 wrAddr,
  input  logic [DATA_W-1:0]                 wrData,
  output logic [NUM_FIELDS-1:0][DATA_W-1:0] fldBus
);
  function automatic logic [DATA_W-1:0] incEnc(input logic [DATA_W-1:0] v, input logic bin);
    if (bin)                 return v + 1'b1;
    else if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                     return v + 1'b1;
  endfunction

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    logic [DATA_W-1:0] q, nxt, bumped;
    logic              hit;

    assign hit = wrEn && (wrAddr == ADDR_W'(i));

    if (i == F_HOUR) begin : g_hour
      always_comb begin
        bumped = incEnc({1'b0, q[6:0]}, st.binEnc);
        nxt = q;
        if (st.step[i]) begin
          nxt[7]   = q[7] ^ st.pmToggle;
          nxt[6:0] = st.wrap[i] ? {6'd0, st.hour12} : bumped[6:0];
        end
      end
    end else begin : g_plain
      always_comb begin
        bumped = incEnc(q, st.binEnc);
        nxt = q;
        if (st.step[i]) nxt = st.wrap[i] ? rstVal(i) : bumped;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n)   q <= rstVal(i);
      else if (hit) q <= wrData;
      else          q <= nxt;
    end

    assign fldBus[i] = q;
  end
endmodule

// File: rtl/cal_time_counter.sv
module cal_time_counter
  import cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              holdSet,
  input  logic              modeBin,
  input  logic              mode24,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  strobe_t                           st;
  logic [NUM_FIELDS-1:0][DATA_W-1:0] fldBus;
  logic [6:0]                        elevenCode;

  cal_ctrl u_ctrl (
    .tick(tick), .holdSet(holdSet), .modeBin(modeBin), .mode24(mode24),
    .fldBus(fldBus), .st(st)
  );

  cal_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .st(st), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .fldBus(fldBus)
  );

  always_comb begin
    rdData = '0;
    for (int k = 0; k < NUM_FIELDS; k++)
      if (rdAddr == ADDR_W'(k)) rdData = fldBus[k];
  end

  assign elevenCode = modeBin ? 7'h0B : 7'h11;

  // R2: a written byte lands in its field
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrAddr == ADDR_W'(F_YEAR)) |=> (fldBus[F_YEAR] == $past(wrData)));

  // R3: an unheld pulse always moves the seconds field
  a_r3_sec_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !holdSet && !wrEn) |=> (fldBus[F_SEC] != $past(fldBus[F_SEC])));

  // R7: while held, nothing changes without a write
  a_r7_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (holdSet && !wrEn) |=> $stable(fldBus));

  // R6: the PM flag only flips when leaving hour 11
  a_r6_pm_at_eleven: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrEn && !mode24 && fldBus[F_HOUR][6:0] != elevenCode) |=> $stable(fldBus[F_HOUR][7]));

  // R8: day never counts to zero
  a_r8_day_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrEn && fldBus[F_DAY] != 8'd0) |=> (fldBus[F_DAY] != 8'd0));

  // R9: month never counts to zero
  a_r9_month_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrEn && fldBus[F_MON] != 8'd0) |=> (fldBus[F_MON] != 8'd0));
endmodule

// File: tb/sim_cal_time_counter.sv
module sim_cal_time_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, holdSet = 1'b0, modeBin = 1'b0, mode24 = 1'b1;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0, rdAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  cal_time_counter u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .holdSet(holdSet), .modeBin(modeBin),
    .mode24(mode24), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  task automatic chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
    rdAddr = a;
    #1;
    checks++;
    if (rdData !== exp) begin
      fails++;
      $display("FAIL %s field %0d: got %h expected %h", tag, a, rdData, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic load(input logic [7:0] h, m, s, d, mo, y, c);
    wr(3'd2, h); wr(3'd1, m); wr(3'd0, s);
    wr(3'd3, d); wr(3'd4, mo); wr(3'd5, y); wr(3'd6, c);
  endtask

  task automatic chkTime(input logic [7:0] h, m, s, input string tag);
    chk(3'd2, h, tag); chk(3'd1, m, tag); chk(3'd0, s, tag);
  endtask

  task automatic t_reset();
    chk(3'd0, 8'h00, "R1"); chk(3'd1, 8'h00, "R1"); chk(3'd2, 8'h00, "R1");
    chk(3'd3, 8'h01, "R1"); chk(3'd4, 8'h01, "R1"); chk(3'd5, 8'h00, "R1");
    chk(3'd6, 8'h00, "R1"); chk(3'd7, 8'h00, "R1");
  endtask

  task automatic t_write();
    wr(3'd5, 8'h80); wr(3'd6, 8'h20);
    chk(3'd5, 8'h80, "R2"); chk(3'd6, 8'h20, "R2");
    wr(3'd5, 8'h11);
    chk(3'd5, 8'h11, "R2"); chk(3'd6, 8'h20, "R2");
  endtask

  task automatic t_bcd();
    modeBin = 1'b0; mode24 = 1'b1;
    load(8'h09, 8'h59, 8'h58, 8'h02, 8'h02, 8'h11, 8'h20);
    pulse(); chkTime(8'h09, 8'h59, 8'h59, "R3");
    pulse(); chkTime(8'h10, 8'h00, 8'h00, "R3");
    wr(3'd0, 8'h09);
    pulse(); chk(3'd0, 8'h10, "R3");
  endtask

  task automatic t_bin();
    modeBin = 1'b1; mode24 = 1'b1;
    load(8'd9, 8'd59, 8'd59, 8'd2, 8'd2, 8'd11, 8'd20);
    pulse(); chkTime(8'd10, 8'd0, 8'd0, "R4");
    wr(3'd0, 8'd9);
    pulse(); chk(3'd0, 8'd10, "R4");
  endtask

  task automatic t_roll24();
    modeBin = 1'b0; mode24 = 1'b1;
    load(8'h23, 8'h59, 8'h59, 8'h05, 8'h03, 8'h11, 8'h20);
    pulse(); chkTime(8'h00, 8'h00, 8'h00, "R5"); chk(3'd3, 8'h06, "R5");
  endtask

  task automatic hr12(input logic [7:0] from, to, input logic [7:0] dayExp);
    load(from, modeBin ? 8'd59 : 8'h59, modeBin ? 8'd59 : 8'h59, 8'h05, 8'h03, 8'h11, 8'h20);
    pulse(); chkTime(to, 8'h00, 8'h00, "R6"); chk(3'd3, dayExp, "R6");
  endtask

  task automatic t_12h();
    modeBin = 1'b0; mode24 = 1'b0;
    hr12(8'h11, 8'h92, 8'h05); hr12(8'h92, 8'h81, 8'h05);
    hr12(8'h91, 8'h12, 8'h06); hr12(8'h12, 8'h01, 8'h05);
    modeBin = 1'b1;
    hr12(8'h0B, 8'h8C, 8'h05); hr12(8'h8C, 8'h81, 8'h05);
    hr12(8'h8B, 8'h0C, 8'h06); hr12(8'h0C, 8'h01, 8'h05);
  endtask

  task automatic t_hold();
    modeBin = 1'b0; mode24 = 1'b1;
    holdSet = 1'b1;
    load(8'h02, 8'h04, 8'h58, 8'h02, 8'h02, 8'h11, 8'h20);
    pulse(); pulse(); pulse();
    chkTime(8'h02, 8'h04, 8'h58, "R7");
    chk(3'd3, 8'h02, "R7"); chk(3'd5, 8'h11, "R7");
    holdSet = 1'b0;
    pulse(); chkTime(8'h02, 8'h04, 8'h59, "R7");
  endtask

  task automatic dayEnd(input logic [7:0] d, mo, y, dExp, moExp);
    load(8'h23, 8'h59, 8'h59, d, mo, y, 8'h20);
    pulse(); chk(3'd3, dExp, "R8"); chk(3'd4, moExp, "R8");
  endtask

  task automatic t_month();
    modeBin = 1'b0; mode24 = 1'b1;
    dayEnd(8'h30, 8'h04, 8'h11, 8'h01, 8'h05);
    dayEnd(8'h30, 8'h05, 8'h11, 8'h31, 8'h05);
    dayEnd(8'h31, 8'h01, 8'h11, 8'h01, 8'h02);
    dayEnd(8'h28, 8'h02, 8'h11, 8'h01, 8'h03);
    dayEnd(8'h28, 8'h02, 8'h12, 8'h29, 8'h02);
    dayEnd(8'h29, 8'h02, 8'h12, 8'h01, 8'h03);
    modeBin = 1'b1;
    dayEnd(8'd28, 8'd2, 8'd12, 8'd29, 8'd2);
    dayEnd(8'd30, 8'd11, 8'd11, 8'd1, 8'd12);
  endtask

  task automatic t_year();
    modeBin = 1'b0; mode24 = 1'b1;
    load(8'h23, 8'h59, 8'h59, 8'h31, 8'h12, 8'h99, 8'h20);
    pulse();
    chk(3'd3, 8'h01, "R9"); chk(3'd4, 8'h01, "R9");
    chk(3'd5, 8'h00, "R9"); chk(3'd6, 8'h21, "R9");
    load(8'h23, 8'h59, 8'h59, 8'h31, 8'h12, 8'h10, 8'h20);
    pulse(); chk(3'd5, 8'h11, "R9"); chk(3'd6, 8'h20, "R9");
    modeBin = 1'b1;
    load(8'd23, 8'd59, 8'd59, 8'd31, 8'd12, 8'd99, 8'd19);
    pulse();
    chk(3'd4, 8'd1, "R9"); chk(3'd5, 8'd0, "R9"); chk(3'd6, 8'd20, "R9");
  endtask

  task automatic t_collide();
    modeBin = 1'b0; mode24 = 1'b1;
    load(8'h05, 8'h10, 8'h10, 8'h02, 8'h02, 8'h11, 8'h20);
    @(negedge clk);
    tick = 1'b1; wrEn = 1'b1; wrAddr = 3'd0; wrData = 8'h33;
    @(negedge clk);
    tick = 1'b0; wrEn = 1'b0;
    chk(3'd0, 8'h33, "R10"); chk(3'd1, 8'h10, "R10");
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_bcd();
    t_bin();
    t_roll24();
    t_12h();
    t_hold();
    t_month();
    t_year();
    t_collide();
    finishRun();
  end
endmodule